// File: doc/BRIEF.md
# Decode Template and Slot Selector

This block decides, once per decode cycle, how the decoder's fetch window is split into slots and what kind of operation goes into each slot. A request carries the type of the operation decoded last, the current decode-cycle number and the number of multiplies issued so far. From these, plus random bytes pulled from a valid/ready byte stream, the block picks one of six slot templates and then one operation type for every slot of that template.

The answer leaves as a single valid/ready beat holding the template number, the slot count, the size of every slot and the chosen type of every slot. Each random decision takes exactly one byte from the stream; decisions fixed by the rules take none. While a byte is needed and none is offered, the block waits.

Operation type codes used on `req_prev_type` and `out_types`: 0 subtract, 1 xor, 2 shifted add, 3 multiply, 4 rotate, 5 add-immediate, 6 xor-immediate, 7 unsigned high multiply, 8 signed high multiply, 9 reciprocal multiply, 15 none.

Top module: `decode_slot_picker`

## Requirements
- R1: After reset the block accepts a request (`req_ready`=1), offers no result (`out_valid`=0) and takes no byte (`rnd_ready`=0).
- R2: Template sizes, slot 0 first: ID0 4,8,4; ID1 7,3,3,3; ID2 3,7,3,3; ID3 4,9,3; ID4 4,4,4,4; ID5 3,3,10. `out_slot_cnt` gives the slot count, `out_sizes` holds slot n at bits [4n+3:4n].
- R3: A previous type of 7 or 8 selects ID5 with no byte taken, ahead of every other rule.
- R4: Otherwise, when the multiply count is below the decode cycle plus one (computed without wrap), ID4 is selected with no byte taken.
- R5: Otherwise, a previous type of 9 takes one byte: bit 0 = 1 gives ID0, bit 0 = 0 gives ID3.
- R6: Otherwise one byte is taken and its bits [1:0] give the template ID 0 to 3.
- R7: A size-3 slot takes one byte; in the last slot bits [1:0] pick 0 subtract, 1 xor, 2 unsigned high multiply, 3 signed high multiply; in any other slot bit 0 picks subtract (0) or xor (1).
- R8: A size-4 slot that is not last in ID4 is a multiply with no byte taken; any other size-4 slot takes one byte whose bit 0 picks rotate (0) or shifted add (1).
- R9: Size-7, 8 and 9 slots take one byte whose bit 0 picks xor-immediate (0) or add-immediate (1); a size-10 slot is always the reciprocal multiply with no byte taken.
- R10: Exactly one byte is consumed per random decision; with no valid byte the block stalls, and it takes no byte while holding a result.
- R11: A result is held stable until `out_ready`; unused slots report size 0 and type 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high |
| req_prev_type | input | 4 | Type code of the previous operation |
| req_decode_cycle | input | CNT_W | Current decode-cycle number |
| req_mul_count | input | CNT_W | Multiplies issued so far |
| rnd_valid | input | 1 | Random byte offered |
| rnd_ready | output | 1 | Random byte taken when high |
| rnd_byte | input | 8 | Random byte |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken when high |
| out_tmpl | output | 3 | Template ID |
| out_slot_cnt | output | 3 | Number of slots in the template |
| out_sizes | output | 16 | Slot sizes, 4 bits per slot |
| out_types | output | 16 | Slot operation types, 4 bits per slot |

## Verification
The bench builds the block with a 4-bit count width instead of the default 8, so the largest decode cycle (15) is reachable in a short directed case and the cycle-plus-one comparison must carry into a fifth bit rather than wrap to zero. Every template is reached through the rule that owns it, including the priority of the high-multiply rule over the multiply-count rule and the equal-count edge of that rule, and the byte stream is throttled and the result back-pressured so the stall and one-byte-per-decision behaviour show up in the count of bytes taken.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  localparam int SLOTS = 4;
  localparam int SZW   = 4;
  localparam int OPW   = 4;
  localparam int TIDW  = 3;
  localparam int IDXW  = $clog2(SLOTS);

  typedef enum logic [OPW-1:0] {
    OP_SUB   = 4'd0,
    OP_XOR   = 4'd1,
    OP_ADDSH = 4'd2,
    OP_MUL   = 4'd3,
    OP_ROT   = 4'd4,
    OP_ADDI  = 4'd5,
    OP_XORI  = 4'd6,
    OP_MULH  = 4'd7,
    OP_SMULH = 4'd8,
    OP_RCP   = 4'd9,
    OP_NONE  = 4'd15
  } op_e;

  typedef logic [SLOTS-1:0][SZW-1:0] size_vec_t;

  localparam logic [TIDW-1:0] TID_QUAD4 = 3'd4;
  localparam logic [TIDW-1:0] TID_TAIL10 = 3'd5;

  // Slot sizes of each template, slot 0 in the lowest element.
  function automatic size_vec_t tmpl_sizes(input logic [TIDW-1:0] id);
    size_vec_t s;
    s = '0;
    case (id)
      3'd0: begin s[0] = 4'd4; s[1] = 4'd8; s[2] = 4'd4; end
      3'd1: begin s[0] = 4'd7; s[1] = 4'd3; s[2] = 4'd3; s[3] = 4'd3; end
      3'd2: begin s[0] = 4'd3; s[1] = 4'd7; s[2] = 4'd3; s[3] = 4'd3; end
      3'd3: begin s[0] = 4'd4; s[1] = 4'd9; s[2] = 4'd3; end
      3'd4: begin s[0] = 4'd4; s[1] = 4'd4; s[2] = 4'd4; s[3] = 4'd4; end
      3'd5: begin s[0] = 4'd3; s[1] = 4'd3; s[2] = 4'd10; end
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [2:0] tmpl_count(input logic [TIDW-1:0] id);
    case (id)
      3'd0, 3'd3, 3'd5: return 3'd3;
      3'd1, 3'd2, 3'd4: return 3'd4;
      default:          return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dsp_tmpl_pick.sv
module dsp_tmpl_pick
  import dsp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  op_e               prev_op,
  input  logic [CNT_W-1:0]  dec_cycle,
  input  logic [CNT_W-1:0]  mul_cnt,
  input  logic [1:0]        sel,
  output logic [TIDW-1:0]   tmpl_id,
  output logic              need_byte
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cycle_plus1;
  logic [EXT_W-1:0] mul_ext;
  logic             mul_behind;

  assign cycle_plus1 = {1'b0, dec_cycle} + EXT_W'(1);
  assign mul_ext     = {1'b0, mul_cnt};
  assign mul_behind  = mul_ext < cycle_plus1;

  always_comb begin
    need_byte = 1'b0;
    tmpl_id   = TID_QUAD4;
    if (prev_op == OP_MULH || prev_op == OP_SMULH) begin
      tmpl_id = TID_TAIL10;
    end else if (mul_behind) begin
      tmpl_id = TID_QUAD4;
    end else if (prev_op == OP_RCP) begin
      need_byte = 1'b1;
      tmpl_id   = sel[0] ? 3'd0 : 3'd3;
    end else begin
      need_byte = 1'b1;
      tmpl_id   = {1'b0, sel};
    end
  end
endmodule

// File: rtl/dsp_slot_decode.sv
module dsp_slot_decode
  import dsp_pkg::*;
(
  input  logic [SZW-1:0]  slot_size,
  input  logic [TIDW-1:0] tmpl_id,
  input  logic            is_last,
  input  logic [1:0]      sel,
  output op_e             op,
  output logic            need_byte
);
  always_comb begin
    need_byte = 1'b1;
    op        = OP_NONE;
    case (slot_size)
      4'd3: begin
        if (is_last) begin
          case (sel)
            2'd0:    op = OP_SUB;
            2'd1:    op = OP_XOR;
            2'd2:    op = OP_MULH;
            default: op = OP_SMULH;
          endcase
        end else begin
          op = sel[0] ? OP_XOR : OP_SUB;
        end
      end
      4'd4: begin
        if (tmpl_id == TID_QUAD4 && !is_last) begin
          need_byte = 1'b0;
          op        = OP_MUL;
        end else begin
          op = sel[0] ? OP_ADDSH : OP_ROT;
        end
      end
      4'd7, 4'd8, 4'd9: op = sel[0] ? OP_ADDI : OP_XORI;
      4'd10: begin
        need_byte = 1'b0;
        op        = OP_RCP;
      end
      default: begin
        need_byte = 1'b0;
        op        = OP_NONE;
      end
    endcase
  end
endmodule

// File: rtl/decode_slot_picker.sv
module decode_slot_picker
  import dsp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [OPW-1:0]         req_prev_type,
  input  logic [CNT_W-1:0]       req_decode_cycle,
  input  logic [CNT_W-1:0]       req_mul_count,
  input  logic                   rnd_valid,
  output logic                   rnd_ready,
  input  logic [7:0]             rnd_byte,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [TIDW-1:0]        out_tmpl,
  output logic [2:0]             out_slot_cnt,
  output logic [SLOTS*SZW-1:0]   out_sizes,
  output logic [SLOTS*OPW-1:0]   out_types
);
  typedef enum logic [1:0] {ST_IDLE, ST_TMPL, ST_SLOT, ST_OUT} st_e;

  st_e                        st_q, st_d;
  logic [OPW-1:0]             prev_q;
  logic [CNT_W-1:0]           cyc_q, mul_q;
  logic [TIDW-1:0]            tmpl_q;
  logic [IDXW-1:0]            idx_q;
  logic [SLOTS-1:0][OPW-1:0]  types_q;

  logic            ld_req, ld_tmpl, ld_slot;
  logic [TIDW-1:0] tp_id;
  logic            tp_need;
  op_e             sd_op;
  logic            sd_need;
  size_vec_t       cur_sizes;
  logic [SZW-1:0]  slot_size;
  logic            slot_last;
  logic            unused_hi_bits;

  assign unused_hi_bits = ^rnd_byte[7:2];

  assign cur_sizes = tmpl_sizes(tmpl_q);
  assign slot_size = cur_sizes[idx_q];
  assign slot_last = ({1'b0, idx_q} + 3'd1) == tmpl_count(tmpl_q);

  dsp_tmpl_pick #(.CNT_W(CNT_W)) u_tmpl (
    .prev_op   (op_e'(prev_q)),
    .dec_cycle (cyc_q),
    .mul_cnt   (mul_q),
    .sel       (rnd_byte[1:0]),
    .tmpl_id   (tp_id),
    .need_byte (tp_need)
  );

  dsp_slot_decode u_slot (
    .slot_size (slot_size),
    .tmpl_id   (tmpl_q),
    .is_last   (slot_last),
    .sel       (rnd_byte[1:0]),
    .op        (sd_op),
    .need_byte (sd_need)
  );

  // Handshakes and next state
  assign req_ready = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);
  assign rnd_ready = ((st_q == ST_TMPL) && tp_need) || ((st_q == ST_SLOT) && sd_need);

  always_comb begin
    st_d    = st_q;
    ld_req  = 1'b0;
    ld_tmpl = 1'b0;
    ld_slot = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        ld_req = 1'b1;
        st_d   = ST_TMPL;
      end
      ST_TMPL: if (!tp_need || rnd_valid) begin
        ld_tmpl = 1'b1;
        st_d    = ST_SLOT;
      end
      ST_SLOT: if (!sd_need || rnd_valid) begin
        ld_slot = 1'b1;
        if (slot_last) st_d = ST_OUT;
      end
      ST_OUT: if (out_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      prev_q  <= OP_NONE;
      cyc_q   <= '0;
      mul_q   <= '0;
      tmpl_q  <= '0;
      idx_q   <= '0;
      types_q <= {SLOTS{OP_NONE}};
    end else begin
      st_q <= st_d;
      if (ld_req) begin
        prev_q <= req_prev_type;
        cyc_q  <= req_decode_cycle;
        mul_q  <= req_mul_count;
      end
      if (ld_tmpl) begin
        tmpl_q  <= tp_id;
        idx_q   <= '0;
        types_q <= {SLOTS{OP_NONE}};
      end
      if (ld_slot) begin
        types_q[idx_q] <= sd_op;
        idx_q          <= idx_q + IDXW'(1);
      end
    end
  end

  assign out_tmpl     = tmpl_q;
  assign out_slot_cnt = tmpl_count(tmpl_q);

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign out_sizes[g*SZW +: SZW] = cur_sizes[g];
    assign out_types[g*OPW +: OPW] = types_q[g];
  end
endmodule

// File: rtl/dsp_checker.sv
module dsp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rnd_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_tmpl,
  input logic [2:0]  out_slot_cnt,
  input logic [15:0] out_sizes,
  input logic [15:0] out_types
);
  AST_TMPL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tmpl <= 3'd5)); // R2

  AST_QUAD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tmpl == 3'd4) |-> (out_sizes == 16'h4444 && out_slot_cnt == 3'd4)); // R2

  AST_QUAD_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tmpl == 3'd4) |-> (out_types[11:0] == 12'h333)); // R8

  AST_TAIL_RCP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tmpl == 3'd5) |-> (out_types[11:8] == 4'd9 && out_sizes[11:8] == 4'd10)); // R9

  AST_NO_TAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!rnd_ready && !req_ready)); // R10

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tmpl) && $stable(out_types) && $stable(out_sizes))); // R11
endmodule

bind decode_slot_picker dsp_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rnd_ready    (rnd_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_tmpl     (out_tmpl),
  .out_slot_cnt (out_slot_cnt),
  .out_sizes    (out_sizes),
  .out_types    (out_types)
);

// File: tb/tb_decode_slot_picker.sv
module tb_decode_slot_picker;
  localparam int CW = 4;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [3:0]    req_prev_type;
  logic [CW-1:0] req_decode_cycle, req_mul_count;
  logic          rnd_valid, rnd_ready;
  logic [7:0]    rnd_byte;
  logic          out_valid, out_ready;
  logic [2:0]    out_tmpl, out_slot_cnt;
  logic [15:0]   out_sizes, out_types;

  decode_slot_picker #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_prev_type(req_prev_type), .req_decode_cycle(req_decode_cycle),
    .req_mul_count(req_mul_count),
    .rnd_valid(rnd_valid), .rnd_ready(rnd_ready), .rnd_byte(rnd_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_tmpl(out_tmpl), .out_slot_cnt(out_slot_cnt),
    .out_sizes(out_sizes), .out_types(out_types)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] pool [0:7];
  int pool_n;
  int used;
  logic [2:0]  cap_tmpl, cap_cnt;
  logic [15:0] cap_sizes, cap_types;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Template sizes from R2, slot 0 in the low nibble
  function automatic logic [15:0] exp_sizes(input int id);
    case (id)
      0: return 16'h0484;
      1: return 16'h3337;
      2: return 16'h3373;
      3: return 16'h0394;
      4: return 16'h4444;
      default: return 16'h0A33;
    endcase
  endfunction

  function automatic int exp_cnt(input int id);
    return (id == 1 || id == 2 || id == 4) ? 4 : 3;
  endfunction

  task automatic load(input logic [39:0] bytes, input int n);
    for (int i = 0; i < 8; i++) pool[i] = 8'hFF;
    for (int i = 0; i < n; i++) pool[i] = bytes[8*i +: 8];
    pool_n = n + 2;
  endtask

  task automatic run_case(input logic [3:0] prev, input int cyc, input int mul,
                          input int gap_every, input int hold);
    bit req_f, rnd_f, out_f, done;
    int k;
    int hold_left;
    used = 0; done = 0; k = 0; hold_left = hold;
    @(negedge clk);
    req_valid = 1'b1;
    req_prev_type = prev;
    req_decode_cycle = CW'(cyc);
    req_mul_count = CW'(mul);
    while (!done && k < 200) begin
      rnd_valid = (used < pool_n) && !(gap_every > 0 && (k % gap_every) != 0);
      rnd_byte  = pool[used];
      if (out_valid && hold_left > 0) begin
        out_ready = 1'b0;
        hold_left--;
      end else begin
        out_ready = 1'b1;
      end
      #1;
      req_f = req_valid && req_ready;
      rnd_f = rnd_valid && rnd_ready;
      out_f = out_valid && out_ready;
      if (out_f) begin
        cap_tmpl = out_tmpl; cap_cnt = out_slot_cnt;
        cap_sizes = out_sizes; cap_types = out_types;
      end
      @(negedge clk);
      if (req_f) req_valid = 1'b0;
      if (rnd_f) used++;
      if (out_f) done = 1;
      k++;
    end
    rnd_valid = 1'b0;
    out_ready = 1'b0;
    req_valid = 1'b0;
    if (!done) chk("timeout", 0, 1);
  endtask

  task automatic expect_result(input string tag, input int id, input logic [15:0] types,
                               input int nbytes);
    chk({tag, " tmpl"}, int'(cap_tmpl), id);
    chk({tag, " R2 slot count"}, int'(cap_cnt), exp_cnt(id));
    chk({tag, " R2 sizes"}, int'(cap_sizes), int'(exp_sizes(id)));
    chk({tag, " types"}, int'(cap_types), int'(types));
    chk({tag, " R10 bytes taken"}, used, nbytes);
  endtask

  // Scenarios
  task automatic t_reset();
    #1;
    chk("R1 req_ready in reset", int'(req_ready), 1);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 rnd_ready", int'(rnd_ready), 0);
  endtask

  task automatic t_quad_first();
    // R4 with no previous op; R8 non-last size-4 is multiply, last uses byte
    load(40'h01, 1);
    run_case(4'd15, 0, 0, 0, 0);
    expect_result("R4 R8 first", 4, 16'h2333, 1);
  endtask

  task automatic t_high_mul();
    // R3 then R7 non-last bit0, R9 size-10, R11 unused slot
    load(40'h0300, 2);
    run_case(4'd7, 5, 0, 0, 0);
    expect_result("R3 R7 R9 R11 mulh", 5, 16'hF910, 2);
    // R3 priority over the multiply-count rule
    load(40'h0001, 2);
    run_case(4'd8, 0, 0, 0, 0);
    expect_result("R3 smulh prio", 5, 16'hF901, 2);
  endtask

  task automatic t_recip();
    // R5 bit0=1 -> ID0; R8 size-4 byte; R9 size 8; held for 3 cycles (R11)
    load(40'h01010001, 4);
    run_case(4'd9, 0, 5, 0, 3);
    expect_result("R5 R8 R9 R11 rcp one", 0, 16'hF254, 4);
    // R5 bit0=0 -> ID3; R9 size 9; R7 last size-3
    load(40'h02000102, 4);
    run_case(4'd9, 0, 5, 0, 0);
    expect_result("R5 R7 R9 rcp zero", 3, 16'hF762, 4);
  endtask

  task automatic t_random_tmpl();
    // R6 equal count is not behind; ID1; R7 non-last ignores bit1
    load(40'h0301020005, 5);
    run_case(4'd0, 1, 2, 0, 0);
    expect_result("R6 R7 id1", 1, 16'h8106, 5);
    // R6 ID2 with a gappy stream (R10 stall)
    load(40'h0000010106, 5);
    run_case(4'd1, 3, 9, 3, 0);
    expect_result("R6 R10 id2 stall", 2, 16'h0051, 5);
    // R6 ID3 via random rule
    load(40'h00010003, 4);
    run_case(4'd2, 2, 3, 0, 0);
    expect_result("R6 id3", 3, 16'hF054, 4);
  endtask

  task automatic t_count_edges();
    // R4 multiply count below cycle+1 at the counter top (needs carry)
    load(40'h01, 1);
    run_case(4'd0, 15, 15, 0, 0);
    expect_result("R4 top carry", 4, 16'h2333, 1);
    load(40'h00, 1);
    run_case(4'd3, 2, 2, 0, 0);
    expect_result("R4 R8 behind", 4, 16'h4333, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_prev_type = 4'd15;
    req_decode_cycle = '0; req_mul_count = '0;
    rnd_valid = 1'b0; rnd_byte = 8'h00; out_ready = 1'b0;
    used = 0; pool_n = 0;
    for (int i = 0; i < 8; i++) pool[i] = 8'hFF;
    t_reset();
    t_quad_first();
    t_high_mul();
    t_recip();
    t_random_tmpl();
    t_count_edges();
    repeat (3) @(negedge clk);
    report();
  end
endmodule